// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Encoder

This block turns a serial stream of bits into a bipolar line code. It takes one bit per clock and drives two output rails: one for positive pulses and one for negative pulses. In single-rail mode it encodes the stream with alternate mark inversion. Runs of zeros are replaced with patterns that contain a deliberate bipolar violation, so the line keeps enough transitions for clock recovery and carries no DC component. The rate select picks the substitution length. Selecting three-zero substitution (B3ZS) suits the DS3 and STS-1 rates. Selecting four-zero substitution (HDB3) suits the E3 rate.

In dual-rail mode the caller supplies pulses that are already encoded. Those pulses pass through to the output rails without substitution. The encoder's polarity and parity state stays frozen during the bypass. Every path has the same latency, so the block can sit in a transmit chain whose timing does not change when the mode changes. To see a whole zero run before its first position is emitted, the block holds the stream in a short pipeline. The substitution is decided when the oldest bit leaves the pipeline.

Top module: `zcs_line_encoder`

## Requirements
- R1: With `sub_hdb3_i`=0 and single-rail input, each run of three zeros, counted from the first zero not already part of a substitution, leaves as B0V or 00V. Zeros left over at the end of a run (fewer than three) leave as zeros.
- R2: With `sub_hdb3_i`=1 and single-rail input, each run of four zeros leaves as B00V or 000V. Runs of one to three zeros leave as zeros.
- R3: The first slot of a substitution is a B pulse when the number of B-type marks since the last V is even, and a zero when it is odd. B-type marks are ordinary ones and substituted B pulses. The count is even after reset and after every V.
- R4: An ordinary one, and a substituted B pulse, take the polarity opposite to the previous mark. After reset the previous mark counts as negative, so the first mark is positive.
- R5: A V pulse repeats the polarity of the previous mark.
- R6: With `single_rail_i`=0 the input rails pass to the output rails with no zero substitution, and the single-rail polarity and parity state is left as it was.
- R7: A bit presented before rising edge n appears on the outputs after rising edge n+3, in every mode and at every rate.
- R8: `line_pos_o` and `line_neg_o` are never high together. A dual-rail input with both rails high produces no pulse.
- R9: A low `rst_n` at a rising edge clears the pipeline, the polarity and the parity. Both outputs are low on the edge after any reset cycle, and they stay low until the first bit after reset reaches the output.
- R10: Output coding: `line_pos_o`=1 is a positive pulse, `line_neg_o`=1 is a negative pulse, and both low is a zero. In single-rail mode `data_neg_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_rail_i | input | 1 | 1: encode the NRZ stream on `data_pos_i`; 0: dual-rail bypass |
| sub_hdb3_i | input | 1 | 1: four-zero substitution (E3); 0: three-zero substitution (DS3/STS-1) |
| data_pos_i | input | 1 | NRZ data in single-rail mode; positive rail in dual-rail mode |
| data_neg_i | input | 1 | Negative rail in dual-rail mode; ignored in single-rail mode |
| line_pos_o | output | 1 | Positive pulse out |
| line_neg_o | output | 1 | Negative pulse out |

## Verification
A corrupted polarity flag shows up at the next ordinary one: two marks of the same polarity appear with no zero run between them. A wrong parity count shows up only at the next zero run, as B-first where zero-first was due, or the other way round. That can take many bits, so the vectors put runs right after odd and even mark counts. A pipeline stage that is lost or doubled shifts every output by a cycle, which the first vector after reset exposes. A stale window after reset would make the pipeline emit pulses before the first data bit arrives.

// File: rtl/zcs_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, the pipeline slot type, and helper functions
// for the zero-substitution encoder. Assumes one bit per clock.
package zcs_pkg;

    // Zero-run lengths replaced at each rate.
    localparam int B3ZS_RUN   = 3;
    localparam int HDB3_RUN   = 4;
    // The longest run minus the slot being decided is the look-ahead depth;
    // the input slot provides the last look-ahead position.
    localparam int WIN_STAGES = HDB3_RUN - 1;

    // Symbol carried by each slot in single-rail mode.
    typedef enum logic [2:0] {
        SYM_SPACE = 3'd0,   // raw zero, not yet substituted
        SYM_MARK  = 3'd1,   // ordinary one (AMI mark)
        SYM_LEAD  = 3'd2,   // first slot of a substitution, B or 0 by parity
        SYM_FILL  = 3'd3,   // zero inside a substitution
        SYM_VIOL  = 3'd4    // violation pulse closing a substitution
    } sym_t;

    // One pipeline slot: valid, mode at entry, symbol, and raw rails for bypass.
    typedef struct packed {
        logic vld;
        logic single;
        sym_t sym;
        logic raw_p;
        logic raw_n;
    } slot_t;

    // Empty slot used at reset.
    localparam slot_t SLOT_IDLE = '{vld: 1'b0, single: 1'b0, sym: SYM_SPACE,
                                    raw_p: 1'b0, raw_n: 1'b0};

    // True when a slot is a single-rail zero that may still start or join a run.
    function automatic logic is_raw_space(slot_t s);
        return s.vld && s.single && (s.sym == SYM_SPACE);
    endfunction

endpackage

// File: rtl/zcs_zero_window.sv
`timescale 1ns/1ps
// Module: zcs_zero_window
// Holds the look-ahead pipeline. When the oldest slot starts a full zero run
// (three or four zeros, chosen by the rate select), it marks the run as
// LEAD / FILL... / VIOL as the slots move toward the output. Whether LEAD
// becomes a pulse is left to the polarity stage, which holds the parity.
// Assumes: the rate select is held steady while a run is in flight.
module zcs_zero_window
    import zcs_pkg::*;
#(
    parameter int STAGES = WIN_STAGES
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hdb3_sel_i,
    input  slot_t in_slot_i,
    output slot_t head_o
);

    localparam int LAST = STAGES;   // index of the head slot in the extended window

    slot_t stg_q [STAGES];
    slot_t ext   [STAGES+1];
    slot_t nxt   [STAGES+1];
    int    run_len;
    logic  trig;

    // Purpose: line up input and stored slots, head at the highest index.
    always_comb begin
        ext[0] = in_slot_i;
        for (int k = 0; k < STAGES; k++) begin
            ext[k+1] = stg_q[k];
        end
    end

    // Purpose: test whether the head slot starts a full raw zero run.
    always_comb begin
        run_len = hdb3_sel_i ? HDB3_RUN : B3ZS_RUN;
        trig    = 1'b1;
        for (int i = 0; i < HDB3_RUN; i++) begin
            if (i < run_len && !is_raw_space(ext[LAST-i])) begin
                trig = 1'b0;
            end
        end
    end

    // Purpose: mark the run as it moves on; otherwise the slots pass unchanged.
    always_comb begin
        for (int k = 0; k <= STAGES; k++) begin
            nxt[k] = ext[k];
        end
        if (trig) begin
            nxt[LAST].sym = SYM_LEAD;
            for (int i = 1; i < HDB3_RUN; i++) begin
                if (i < run_len - 1) begin
                    nxt[LAST-i].sym = SYM_FILL;
                end else if (i == run_len - 1) begin
                    nxt[LAST-i].sym = SYM_VIOL;
                end
            end
        end
    end

    assign head_o = nxt[LAST];

    // Purpose: advance the pipeline one slot per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= SLOT_IDLE;
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= nxt[k];
            end
        end
    end

    // R1: a three-zero substitution closes with its V two slots after LEAD.
    assert_b3zs_viol_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (head_o.vld && head_o.single && head_o.sym == SYM_LEAD && !hdb3_sel_i)
        |=> ##1 (head_o.sym == SYM_VIOL));

    // R2: a four-zero substitution closes with its V three slots after LEAD.
    assert_hdb3_viol_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (head_o.vld && head_o.single && head_o.sym == SYM_LEAD && hdb3_sel_i)
        |=> ##2 (head_o.sym == SYM_VIOL));

    // R1/R2: a filler zero only ever follows LEAD or another filler.
    assert_fill_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (head_o.sym == SYM_FILL) |-> ($past(head_o.sym) == SYM_LEAD || $past(head_o.sym) == SYM_FILL));

endmodule

// File: rtl/zcs_mark_polarizer.sv
`timescale 1ns/1ps
// Module: zcs_mark_polarizer
// Turns the head slot into registered rail pulses. It keeps the polarity of
// the last mark and the parity of B-type marks since the last violation.
// A LEAD slot becomes a B pulse when that parity is even and a zero when it
// is odd. Dual-rail slots are copied to the rails, and a slot with both rails
// high becomes no pulse. Assumes the slot comes from zcs_zero_window.
module zcs_mark_polarizer
    import zcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_i,
    output logic  line_pos_o,
    output logic  line_neg_o
);

    logic last_pos_q;   // 1: the previous mark was positive
    logic odd_q;        // 1: an odd number of B-type marks since the last V
    logic pulse_p, pulse_n, emit_b;
    logic last_pos_d, odd_d;

    // Purpose: choose the pulse for this slot and the next polarity/parity state.
    always_comb begin
        pulse_p    = 1'b0;
        pulse_n    = 1'b0;
        emit_b     = 1'b0;
        last_pos_d = last_pos_q;
        odd_d      = odd_q;
        if (slot_i.vld) begin
            if (!slot_i.single) begin
                pulse_p = slot_i.raw_p & ~slot_i.raw_n;
                pulse_n = slot_i.raw_n & ~slot_i.raw_p;
            end else begin
                case (slot_i.sym)
                    SYM_MARK: emit_b = 1'b1;
                    SYM_LEAD: emit_b = ~odd_q;
                    SYM_VIOL: begin
                        pulse_p = last_pos_q;
                        pulse_n = ~last_pos_q;
                        odd_d   = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
        if (emit_b) begin
            pulse_p    = ~last_pos_q;
            pulse_n    = last_pos_q;
            last_pos_d = ~last_pos_q;
            odd_d      = ~odd_q;
        end
    end

    // Purpose: register the rails and the encoder state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pos_o <= 1'b0;
            line_neg_o <= 1'b0;
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
        end else begin
            line_pos_o <= pulse_p;
            line_neg_o <= pulse_n;
            last_pos_q <= last_pos_d;
            odd_q      <= odd_d;
        end
    end

    // R8: the two rails are never driven together.
    assert_rails_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos_o && line_neg_o));

    // R4: an ordinary mark flips the stored polarity.
    assert_mark_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i.vld && slot_i.single && slot_i.sym == SYM_MARK)
        |=> (last_pos_q != $past(last_pos_q)));

    // R5: a violation leaves with the previous mark's polarity.
    assert_viol_repeats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i.vld && slot_i.single && slot_i.sym == SYM_VIOL)
        |=> (line_pos_o == $past(last_pos_q) && line_neg_o == !$past(last_pos_q)));

    // R3: the parity count is even after each violation.
    assert_parity_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i.vld && slot_i.single && slot_i.sym == SYM_VIOL) |=> !odd_q);

    // R6: a bypass slot is copied out and leaves the encoder state alone.
    assert_bypass_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i.vld && !slot_i.single && !(slot_i.raw_p && slot_i.raw_n))
        |=> (line_pos_o == $past(slot_i.raw_p) && line_neg_o == $past(slot_i.raw_n)
             && $stable(last_pos_q) && $stable(odd_q)));

    // R9: both rails are low after any reset cycle.
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!line_pos_o && !line_neg_o));

endmodule

// File: rtl/zcs_line_encoder.sv
`timescale 1ns/1ps
// Module: zcs_line_encoder (top)
// Bipolar line encoder with three- or four-zero substitution and a dual-rail
// bypass. Each input bit is packed into a pipeline slot. The slot is taken
// through the look-ahead window and then through the polarity stage. The
// latency is four clocks on every path.
// Assumes: one bit per clock; the rate select is held steady during traffic.
module zcs_line_encoder
    import zcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic single_rail_i,
    input  logic sub_hdb3_i,
    input  logic data_pos_i,
    input  logic data_neg_i,
    output logic line_pos_o,
    output logic line_neg_o
);

    slot_t in_slot;
    slot_t head;

    // Purpose: pack the current inputs into a slot; NRZ bit sets the symbol.
    always_comb begin
        in_slot.vld    = 1'b1;
        in_slot.single = single_rail_i;
        in_slot.sym    = data_pos_i ? SYM_MARK : SYM_SPACE;
        in_slot.raw_p  = data_pos_i;
        in_slot.raw_n  = data_neg_i;
    end

    zcs_zero_window #(
        .STAGES (WIN_STAGES)
    ) window_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdb3_sel_i (sub_hdb3_i),
        .in_slot_i  (in_slot),
        .head_o     (head)
    );

    zcs_mark_polarizer polarizer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (head),
        .line_pos_o (line_pos_o),
        .line_neg_o (line_neg_o)
    );

endmodule

// File: tb/zcs_line_encoder_tb_top.sv
`timescale 1ns/1ps
// Bench: a table of 12-bit sequences, first bit at the MSB, with the expected
// rails. Each run starts from reset. After the table come directed checks.
module zcs_line_encoder_tb_top;

    typedef struct packed {
        logic        hdb3;
        logic [11:0] in_s;    // per-bit mode: 1 single-rail
        logic [11:0] in_p;
        logic [11:0] in_n;
        logic [11:0] exp_p;
        logic [11:0] exp_n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R1 R3 R10: B3ZS, odd then even counts; negative input ignored
        '{1'b0, 12'hFFF, 12'h8C0, 12'hFFF, 12'h945, 12'h0A8},
        // R2 R3: HDB3, 000V twice, leftover two zeros
        '{1'b1, 12'hFFF, 12'h840, 12'h5A5, 12'h880, 12'h044},
        // R2 R5: HDB3 all zeros, B00V three times
        '{1'b1, 12'hFFF, 12'h000, 12'h000, 12'h909, 12'h090},
        // R4: B3ZS with short runs only, plain AMI
        '{1'b0, 12'hFFF, 12'h967, 12'h3C3, 12'h845, 12'h122},
        // R1 R3 R5: B3ZS with even counts then odd
        '{1'b0, 12'hFFF, 12'h188, 12'h000, 12'hA89, 12'h150},
        // R6 R8: dual-rail bypass with a both-high bit
        '{1'b0, 12'h000, 12'h842, 12'h441, 12'h802, 12'h401},
        // R2 R4: HDB3 with three-zero runs, no substitution
        '{1'b1, 12'hFFF, 12'h88D, 12'h000, 12'h809, 12'h084},
        // R6: bypass in the middle of single-rail marks leaves polarity alone
        '{1'b0, 12'h8FF, 12'hDFF, 12'h200, 12'hD55, 12'h2AA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic single_rail_i = 1'b1;
    logic sub_hdb3_i = 1'b0;
    logic data_pos_i = 1'b0;
    logic data_neg_i = 1'b0;
    logic line_pos_o, line_neg_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    zcs_line_encoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .single_rail_i (single_rail_i),
        .sub_hdb3_i    (sub_hdb3_i),
        .data_pos_i    (data_pos_i),
        .data_neg_i    (data_neg_i),
        .line_pos_o    (line_pos_o),
        .line_neg_o    (line_neg_o)
    );

    task automatic check_rails(string req, logic ep, logic en);
        checks++;
        if (line_pos_o !== ep || line_neg_o !== en) begin
            failures++;
            $display("FAIL %s: pos=%0b neg=%0b expected pos=%0b neg=%0b",
                     req, line_pos_o, line_neg_o, ep, en);
        end
    endtask

    // Hold reset two cycles and check the quiet rails (R9); returns at a negedge.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        data_pos_i = 1'b0;
        data_neg_i = 1'b0;
        repeat (2) @(negedge clk);
        check_rails("R9 reset state", 1'b0, 1'b0);
    endtask

    // Feed a vector; bit k is due at the negedge four cycles later (R7).
    task automatic run_vec(vec_t v, int idx);
        logic flush_single;
        apply_reset();
        sub_hdb3_i = v.hdb3;
        flush_single = v.in_s[0];
        for (int i = 0; i < 16; i++) begin
            if (i >= 1 && i <= 3) begin
                check_rails($sformatf("R9 idle before data, vector %0d", idx), 1'b0, 1'b0);
            end
            if (i >= 4) begin
                check_rails($sformatf("R7 vector %0d bit %0d", idx, i - 4),
                            v.exp_p[15-i], v.exp_n[15-i]);
            end
            rst_n = 1'b1;
            if (i < 12) begin
                single_rail_i = v.in_s[11-i];
                data_pos_i    = v.in_p[11-i];
                data_neg_i    = v.in_n[11-i];
            end else begin
                single_rail_i = flush_single;
                data_pos_i    = flush_single;
                data_neg_i    = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v], v);
        end

        // R9 R4: reset during traffic clears polarity; the next mark is positive.
        apply_reset();
        single_rail_i = 1'b1;
        sub_hdb3_i = 1'b0;
        rst_n = 1'b1;
        data_pos_i = 1'b1;
        repeat (5) @(negedge clk);          // marks +,- have reached the rails
        rst_n = 1'b0;
        @(negedge clk);
        check_rails("R9 reset mid-stream", 1'b0, 1'b0);
        rst_n = 1'b1;
        data_pos_i = 1'b1;
        repeat (4) @(negedge clk);
        check_rails("R4 first mark after reset positive", 1'b1, 1'b0);
        @(negedge clk);
        check_rails("R4 second mark negative", 1'b0, 1'b1);

        // R8: both rails high in bypass every cycle gives no pulse.
        apply_reset();
        rst_n = 1'b1;
        single_rail_i = 1'b0;
        data_pos_i = 1'b1;
        data_neg_i = 1'b1;
        repeat (4) @(negedge clk);
        check_rails("R8 both-high bypass", 1'b0, 1'b0);
        @(negedge clk);
        check_rails("R8 both-high bypass held", 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule